// File: doc/BRIEF.md
# Panel Bus Strobe Timing Engine

This block runs an 8080-style 8-bit parallel bus toward a display panel that contains its own controller. It drives an active-low chip select, the A0 line (which selects command or data on the panel side), active-low write and read strobes and an output enable for the data byte. Each transfer is started by a one-cycle request carrying the direction, the A0 value and the write byte. The block reports completion with a one-cycle acknowledge, and a read returns the byte it captured from the bus.

Every phase of a transfer is programmed in controller clock cycles: the A0/chip-select setup and hold, the strobe low time, the time control stays stable after a read strobe, and the idle gap that must follow a write. Reads and writes share the setup/hold value and the strobe width. A programmed value of zero gives the same timing as one. The timing inputs are taken only when a request is accepted. Software converts nanoseconds to cycles before programming them.

Top module: `pbus_strobe_engine`

## Requirements
- R1: While reset is asserted and after it is released, cs_n, wr_n and rd_n are high, bus_oe and ack are low, and req_ready is high.
- R2: After a request is accepted, cs_n is low and bus_a0 equals the requested A0 for exactly max(cfg_setup,1) cycles before the strobe goes low.
- R3: The strobe that matches the direction (wr_n for req_read=0, rd_n for req_read=1) stays low for exactly max(cfg_width,1) cycles. The other strobe stays high, and no strobe is low while cs_n is high.
- R4: After wr_n returns high, cs_n stays low for exactly max(cfg_setup,1) cycles.
- R5: After rd_n returns high, cs_n stays low for exactly max(cfg_ohold,1) cycles. Then cs_n rises and ack is high in the first cycle that cs_n is high.
- R6: rd_data takes the bus_din value present in the last cycle in which rd_n is low. It holds that value through writes until the next read captures a new one.
- R7: After a write, once cs_n has risen, req_ready stays low and cs_n stays high for exactly max(cfg_inhibit,1) cycles. ack is high in the first of these cycles. No inhibit gap follows a read.
- R8: During a write, bus_oe is high and bus_dout equals the request byte in every cycle in which cs_n is low. bus_oe is low during reads and when idle.
- R9: A timing value of 0 produces the same phase lengths as a value of 1.
- R10: Timing inputs are sampled only in the accepting cycle. Changes to them during a transfer do not alter that transfer's phases.
- R11: req_ready is high only when the engine is idle, and a request is accepted only while req_ready is high; a request presented while req_ready is low is ignored. Each accepted transfer produces exactly one single-cycle ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_setup | input | TW | A0/CS setup and write hold, in cycles |
| cfg_width | input | TW | Strobe low time, in cycles |
| cfg_ohold | input | TW | Hold after read strobe, in cycles |
| cfg_inhibit | input | TW | Idle gap after a write, in cycles |
| req_valid | input | 1 | Transfer request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_a0 | input | 1 | A0 level for the transfer |
| req_wdata | input | DW | Byte to write |
| req_ready | output | 1 | Engine idle, request accepted this cycle |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Last byte read from the panel |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_a0 | output | 1 | Command/data select |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_oe | output | 1 | Data output enable |
| bus_dout | output | DW | Data driven toward the panel |
| bus_din | input | DW | Data returned from the panel |

## Verification
The bench builds the engine with TW=5 and DW=8. The five-bit counter limits every phase to 31 cycles, so each timing value, including the top of its range, fits in a transfer of about a hundred cycles. This lets hundreds of random transfers with random phase lengths run, alongside directed zero, one and maximum settings. The bench changes the timing inputs mid-transfer and drives a new random bus byte in each strobe cycle, so the captured byte and the measured phase lengths are distinguishable from wrong ones.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_STROBE  = 3'd2,
    PH_HOLD    = 3'd3,
    PH_INHIBIT = 3'd4
  } phase_e;

  // Chip select is driven low in these phases.
  function automatic logic phase_selects(input phase_e p);
    return (p == PH_SETUP) || (p == PH_STROBE) || (p == PH_HOLD);
  endfunction
endpackage

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          done
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt;

  // A phase lasts max(len,1) cycles, so the counter starts at that minus one.
  function automatic logic [TW-1:0] start_value(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= start_value(len);
    else if (cnt != '0)  cnt <= cnt - ONE;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pbus_phase_seq.sv
module pbus_phase_seq
  import pbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   is_read,
  input  logic   timer_done,
  output phase_e ph,
  output phase_e ph_nxt,
  output logic   load,
  output logic   xfer_end
);
  always_comb begin
    ph_nxt = ph;
    unique case (ph)
      PH_IDLE:    if (start)      ph_nxt = PH_SETUP;
      PH_SETUP:   if (timer_done) ph_nxt = PH_STROBE;
      PH_STROBE:  if (timer_done) ph_nxt = PH_HOLD;
      PH_HOLD:    if (timer_done) ph_nxt = is_read ? PH_IDLE : PH_INHIBIT;
      PH_INHIBIT: if (timer_done) ph_nxt = PH_IDLE;
      default:                    ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_IDLE;
    else        ph <= ph_nxt;
  end

  assign load     = (ph_nxt != ph) && (ph_nxt != PH_IDLE);
  assign xfer_end = (ph == PH_HOLD) && timer_done;
endmodule

// File: rtl/pbus_strobe_engine.sv
module pbus_strobe_engine
  import pbus_pkg::*;
#(
  parameter int TW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cfg_setup,
  input  logic [TW-1:0] cfg_width,
  input  logic [TW-1:0] cfg_ohold,
  input  logic [TW-1:0] cfg_inhibit,
  input  logic          req_valid,
  input  logic          req_read,
  input  logic          req_a0,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          ack,
  output logic [DW-1:0] rd_data,
  output logic          bus_cs_n,
  output logic          bus_a0,
  output logic          bus_wr_n,
  output logic          bus_rd_n,
  output logic          bus_oe,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din
);
  localparam int CW = 4 * TW;

  phase_e        ph, ph_nxt;
  logic          start, load, tdone, xfer_end, cap_evt, selecting;
  logic [TW-1:0] setup_q, width_q, ohold_q, inhib_q, len;
  logic          rd_q, a0_q;
  logic [DW-1:0] wd_q;
  logic [CW-1:0] cfg_snap;

  assign start     = req_valid && (ph == PH_IDLE);
  assign selecting = phase_selects(ph);
  assign cap_evt   = (ph == PH_STROBE) && tdone && rd_q;
  assign cfg_snap  = {setup_q, width_q, ohold_q, inhib_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      width_q <= '0;
      ohold_q <= '0;
      inhib_q <= '0;
      rd_q    <= 1'b0;
      a0_q    <= 1'b0;
      wd_q    <= '0;
    end else if (start) begin
      setup_q <= cfg_setup;
      width_q <= cfg_width;
      ohold_q <= cfg_ohold;
      inhib_q <= cfg_inhibit;
      rd_q    <= req_read;
      a0_q    <= req_a0;
      wd_q    <= req_wdata;
    end
  end

  // Length of the phase being entered; the setup phase uses the live input
  // because the snapshot is written on the same edge.
  always_comb begin
    unique case (ph_nxt)
      PH_SETUP:   len = start ? cfg_setup : setup_q;
      PH_STROBE:  len = width_q;
      PH_HOLD:    len = rd_q ? ohold_q : setup_q;
      PH_INHIBIT: len = inhib_q;
      default:    len = '0;
    endcase
  end

  pbus_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .is_read    (rd_q),
    .timer_done (tdone),
    .ph         (ph),
    .ph_nxt     (ph_nxt),
    .load       (load),
    .xfer_end   (xfer_end)
  );

  pbus_phase_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .len   (len),
    .done  (tdone)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack     <= 1'b0;
      rd_data <= '0;
    end else begin
      ack <= xfer_end;
      if (cap_evt) rd_data <= bus_din;
    end
  end

  assign req_ready = (ph == PH_IDLE);
  assign bus_cs_n  = !selecting;
  assign bus_a0    = selecting && a0_q;
  assign bus_wr_n  = !((ph == PH_STROBE) && !rd_q);
  assign bus_rd_n  = !((ph == PH_STROBE) && rd_q);
  assign bus_oe    = selecting && !rd_q;
  assign bus_dout  = bus_oe ? wd_q : '0;
endmodule

// File: rtl/pbus_strobe_chk.sv
module pbus_strobe_chk
  import pbus_pkg::*;
#(
  parameter int TW = 8,
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_cs_n,
  input logic            bus_wr_n,
  input logic            bus_rd_n,
  input logic            bus_oe,
  input logic            req_ready,
  input logic            ack,
  input logic [DW-1:0]   rd_data,
  input phase_e          ph,
  input logic            cap_evt,
  input logic [4*TW-1:0] cfg_snap
);
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_wr_n && !bus_rd_n));

  a_r3_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n || !bus_rd_n) |-> !bus_cs_n);

  a_r2_cs_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> (bus_wr_n && bus_rd_n));

  a_r4_strobe_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> ($past(bus_wr_n) && $past(bus_rd_n)));

  a_r8_oe_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!bus_cs_n && bus_rd_n));

  a_r11_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r11_ack_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(ph == PH_HOLD));

  a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(cfg_snap));

  a_r6_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_evt) |-> $stable(rd_data));

  a_r7_inhibit_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_INHIBIT) |-> (bus_cs_n && !req_ready));
endmodule

bind pbus_strobe_engine pbus_strobe_chk #(.TW(TW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_cs_n  (bus_cs_n),
  .bus_wr_n  (bus_wr_n),
  .bus_rd_n  (bus_rd_n),
  .bus_oe    (bus_oe),
  .req_ready (req_ready),
  .ack       (ack),
  .rd_data   (rd_data),
  .ph        (ph),
  .cap_evt   (cap_evt),
  .cfg_snap  (cfg_snap)
);

// File: tb/sim_pbus_strobe_engine.sv
module sim_pbus_strobe_engine;
  localparam int TW = 5;
  localparam int DW = 8;
  localparam int TMAX = (1 << TW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] cfg_setup = '0, cfg_width = '0, cfg_ohold = '0, cfg_inhibit = '0;
  logic req_valid = 1'b0, req_read = 1'b0, req_a0 = 1'b0;
  logic [DW-1:0] req_wdata = '0, bus_din = '0;
  logic req_ready, ack, bus_cs_n, bus_a0, bus_wr_n, bus_rd_n, bus_oe;
  logic [DW-1:0] rd_data, bus_dout;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] last_rd = '0;

  always #5 clk = ~clk;

  pbus_strobe_engine #(.TW(TW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_setup(cfg_setup), .cfg_width(cfg_width),
    .cfg_ohold(cfg_ohold), .cfg_inhibit(cfg_inhibit),
    .req_valid(req_valid), .req_read(req_read), .req_a0(req_a0),
    .req_wdata(req_wdata), .req_ready(req_ready), .ack(ack),
    .rd_data(rd_data), .bus_cs_n(bus_cs_n), .bus_a0(bus_a0),
    .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_oe(bus_oe),
    .bus_dout(bus_dout), .bus_din(bus_din)
  );

  function automatic int eff_len(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Entered at a negedge with req_ready high; leaves at a negedge with req_ready high.
  task automatic run_xfer(input bit rd, input bit a0, input logic [DW-1:0] wd,
                          input int s, input int w, input int o, input int ih,
                          input bit scramble);
    int pre = 0, str = 0, post = 0, inh = 0, acks = 0, guard = 0;
    int ack_where = 0, bad_drive = 0, bad_a0 = 0, bad_strobe = 0;
    bit seen = 0;
    logic [DW-1:0] cap = last_rd;
    cfg_setup = TW'(s); cfg_width = TW'(w); cfg_ohold = TW'(o); cfg_inhibit = TW'(ih);
    req_valid = 1'b1; req_read = rd; req_a0 = a0; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = DW'($urandom);
    if (scramble) begin
      cfg_setup = TW'($urandom); cfg_width = TW'($urandom);
      cfg_ohold = TW'($urandom); cfg_inhibit = TW'($urandom);
    end
    while (guard < 1000) begin
      guard++;
      if (ack) begin
        acks++;
        ack_where = !bus_cs_n ? 1 : (!req_ready ? 2 : 3);
      end
      if (!bus_cs_n) begin
        if (bus_a0 !== a0) bad_a0++;
        if (rd ? (bus_oe !== 1'b0) : (bus_oe !== 1'b1 || bus_dout !== wd)) bad_drive++;
        if (!bus_wr_n || !bus_rd_n) begin
          str++; seen = 1;
          if (rd ? (bus_rd_n !== 1'b0 || bus_wr_n !== 1'b1)
                 : (bus_wr_n !== 1'b0 || bus_rd_n !== 1'b1)) bad_strobe++;
          if (rd) begin bus_din = DW'($urandom); cap = bus_din; end
        end else if (!seen) pre++;
        else post++;
      end else begin
        if (!bus_wr_n || !bus_rd_n) bad_strobe++;
        if (!req_ready) inh++;
        else break;
      end
      @(negedge clk);
    end
    chk(guard < 1000, "R11 transfer completes", guard, 1000);
    chk(pre == eff_len(s), scramble ? "R2 R10 setup length" : "R2 setup length", pre, eff_len(s));
    chk(bad_a0 == 0, "R2 a0 level", bad_a0, 0);
    chk(str == eff_len(w), scramble ? "R3 R10 strobe width" : "R3 strobe width", str, eff_len(w));
    chk(bad_strobe == 0, "R3 strobe selection", bad_strobe, 0);
    if (rd) begin
      chk(post == eff_len(o), "R5 read output hold", post, eff_len(o));
      chk(inh == 0, "R7 no gap after read", inh, 0);
      chk(ack_where == 3, "R5 ack position", ack_where, 3);
      chk(rd_data == cap, "R6 captured byte", rd_data, cap);
      last_rd = cap;
    end else begin
      chk(post == eff_len(s), "R4 write hold", post, eff_len(s));
      chk(inh == eff_len(ih), scramble ? "R7 R10 inhibit gap" : "R7 inhibit gap", inh, eff_len(ih));
      chk(ack_where == 2, "R7 ack position", ack_where, 2);
      chk(rd_data == last_rd, "R6 byte held over write", rd_data, last_rd);
    end
    chk(bad_drive == 0, "R8 data drive", bad_drive, 0);
    chk(acks == 1, "R11 single ack", acks, 1);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    @(negedge clk);
    chk(bus_cs_n && bus_wr_n && bus_rd_n && !bus_oe && !ack && req_ready,
        "R1 outputs in reset", {bus_cs_n, bus_wr_n, bus_rd_n, bus_oe, ack, req_ready}, 6'b111001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_cs_n && bus_wr_n && bus_rd_n && !bus_oe && !ack && req_ready,
        "R1 outputs after reset", {bus_cs_n, bus_wr_n, bus_rd_n, bus_oe, ack, req_ready}, 6'b111001);

    // R9: zero behaves as one, compared against the all-ones run.
    run_xfer(1'b0, 1'b1, 8'hA5, 0, 0, 0, 0, 1'b0);
    run_xfer(1'b1, 1'b0, 8'h00, 0, 0, 0, 0, 1'b0);
    run_xfer(1'b0, 1'b0, 8'h3C, 1, 1, 1, 1, 1'b0);
    run_xfer(1'b1, 1'b1, 8'h00, 1, 1, 1, 1, 1'b0);
    run_xfer(1'b0, 1'b1, 8'hFF, TMAX, TMAX, TMAX, TMAX, 1'b0);
    run_xfer(1'b1, 1'b0, 8'h00, TMAX, TMAX, TMAX, TMAX, 1'b0);
    // R10: timing inputs change right after acceptance.
    run_xfer(1'b0, 1'b1, 8'h5A, 3, 4, 2, 5, 1'b1);
    run_xfer(1'b1, 1'b1, 8'h00, 2, 6, 7, 1, 1'b1);

    // R11: a request while busy is ignored.
    begin
      int acks = 0, extra = 0;
      cfg_setup = TW'(2); cfg_width = TW'(2); cfg_ohold = TW'(2); cfg_inhibit = TW'(2);
      req_valid = 1'b1; req_read = 1'b0; req_a0 = 1'b0; req_wdata = 8'h81;
      @(negedge clk); req_valid = 1'b0;
      @(negedge clk); req_valid = 1'b1; req_read = 1'b1; req_a0 = 1'b1;
      chk(!req_ready, "R11 ready low while busy", req_ready, 0);
      @(negedge clk); req_valid = 1'b0;
      for (int k = 0; k < 30; k++) begin
        if (ack) acks++;
        if (!bus_rd_n) extra++;
        @(negedge clk);
      end
      chk(acks == 1, "R11 busy request ignored acks", acks, 1);
      chk(extra == 0, "R11 busy request ignored strobe", extra, 0);
      chk(req_ready && bus_cs_n, "R11 idle afterwards", {req_ready, bus_cs_n}, 2'b11);
    end

    for (int n = 0; n < 250; n++) begin
      run_xfer(1'($urandom), 1'($urandom), DW'($urandom),
               int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
               int'($urandom % 8), 1'($urandom));
    end
    run_xfer(1'b1, 1'b0, 8'h00, 0, TMAX, 0, 0, 1'b1);
    run_xfer(1'b0, 1'b0, 8'h77, TMAX, 0, TMAX, 0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule